// File: doc/BRIEF.md
# Byte ALU with Registered Status Flags

This block is the arithmetic and logic stage of a small 8-bit RISC core. It takes two operands and a five-bit operation code and returns a byte result within the same cycle. An eight-bit status word is held in a register inside the block. When an operation is issued, each operation rewrites only the flags it owns, and every other flag keeps its stored value. The stored carry and transfer flags feed back as the carry-in, the borrow-in and the bit source. Add-with-carry and subtract-with-carry can therefore be chained across bytes without outside help.

The status word is ordered C at bit 0, then Z, N, V, S, H, T, and I at bit 7. The bit-index operations depend on this order. The sign flag S is always recomputed as N XOR V by any operation that writes N or V. The register file, word-wide arithmetic, multiply and instruction decode sit outside this block.

Top module: `ralu_core`

## Requirements
- R1: While `rst_n` is low the flag word reads 0x00, and it stays 0x00 until the first issued operation.
- R2: ADD (op 0) and ADC (op 1) return opa+opb (+C for ADC, using the stored carry). They set C to the carry out of bit 7, H to the carry out of bit 3, V to the signed overflow, N to result bit 7 and Z to result==0.
- R3: SUB (op 2), SBC (op 3), CP (op 4) and CPC (op 5) return opa−opb (−C for SBC and CPC, using the stored carry as borrow). They set C to the borrow out of bit 7, H to the borrow into bit 4, V to the signed overflow, and N and Z from the result.
- R4: AND (op 6), OR (op 7) and XOR (op 8) return the bitwise result. They set N and Z from it and clear V. C and H are kept.
- R5: INC (op 11) returns opa+1 with V set only for 0x7F. DEC (op 12) returns opa−1 with V set only for 0x80. Both set N and Z, and both keep C and H.
- R6: COM (op 9) returns 0xFF−opa, sets C and clears V. NEG (op 10) returns 0x00−opa. NEG sets C when the result is non-zero, sets V only for a result of 0x80, and sets H when the low nibble of opa is non-zero.
- R7: LSL (op 13) clears bit 0. LSR (op 14) clears bit 7. ROL (op 15) fills bit 0 from the stored C. ROR (op 16) fills bit 7 from the stored C. ASR (op 17) keeps bit 7. For left moves C takes the old bit 7, and for right moves it takes the old bit 0. V becomes N XOR C, and H is kept.
- R8: SWAP (op 18) exchanges the two nibbles of opa. PASS (op 23) returns opa. Neither changes any flag.
- R9: FSET (op 19) sets and FCLR (op 20) clears the single flag whose bit position is opb[2:0]. The result is opa, and S is not recomputed by these two.
- R10: TSTORE (op 21) copies opa bit opb[2:0] into T (flag bit 6) and returns opa. TLOAD (op 22) returns opa with bit opb[2:0] replaced by T and changes no flag.
- R11: After any operation from R2 to R7, flag S equals N XOR V.
- R12: While `op_valid` is low the flag word holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flag word |
| op_valid | input | 1 | Commits the selected operation's flag update at the next edge |
| op_sel | input | 5 | Operation code (see requirements) |
| opa | input | 8 | First operand / destination value |
| opb | input | 8 | Second operand; bits 2..0 give the bit index for bit operations |
| result | output | 8 | Combinational result from the current inputs and stored flags |
| flags | output | 8 | Registered status word {I,T,H,S,V,N,Z,C} |

## Verification
The result is due in the same cycle as its operands, because it is combinational from the inputs and the stored flags. The updated flags are due one rising edge later. The bench drives each operation on a falling edge and checks the result 1 ns afterwards, before any edge can disturb the stored carry. The matching flag word is then checked 1 ns after the next rising edge, before new stimulus arrives. The scoreboard keeps its own copy of the flags, advanced item by item. This lets carry-dependent operations such as ADC, SBC, ROL and TLOAD be predicted from the flag state the design should hold at that moment.

// File: rtl/ralu_pkg.sv
package ralu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADC   = 5'd1,
        OP_SUB   = 5'd2,
        OP_SBC   = 5'd3,
        OP_CP    = 5'd4,
        OP_CPC   = 5'd5,
        OP_AND   = 5'd6,
        OP_OR    = 5'd7,
        OP_XOR   = 5'd8,
        OP_COM   = 5'd9,
        OP_NEG   = 5'd10,
        OP_INC   = 5'd11,
        OP_DEC   = 5'd12,
        OP_LSL   = 5'd13,
        OP_LSR   = 5'd14,
        OP_ROL   = 5'd15,
        OP_ROR   = 5'd16,
        OP_ASR   = 5'd17,
        OP_SWAP  = 5'd18,
        OP_FSET  = 5'd19,
        OP_FCLR  = 5'd20,
        OP_TST   = 5'd21,
        OP_TLD   = 5'd22,
        OP_PASS  = 5'd23
    } alu_op_e;

    // packed from bit 7 down to bit 0; bit positions are addressed by FSET/FCLR
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flag_t;

    localparam int FLAG_BITS = 8;
    localparam int FLAG_IDX_W = $clog2(FLAG_BITS);

endpackage

// File: rtl/ralu_addsub.sv
module ralu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c,
    output logic         h,
    output logic         v
);
    localparam int HALF = W / 2;

    logic [W:0] full;

    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
        end else begin
            full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        end
        r = full[W-1:0];
        c = full[W];
        // carry (or borrow) entering bit HALF
        h = x[HALF] ^ y[HALF] ^ full[HALF];
        if (sub) begin
            v = (x[W-1] ^ y[W-1]) & (x[W-1] ^ full[W-1]);
        end else begin
            v = ~(x[W-1] ^ y[W-1]) & (x[W-1] ^ full[W-1]);
        end
    end

endmodule

// File: rtl/ralu_bitops.sv
module ralu_bitops
    import ralu_pkg::*;
#(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [IW-1:0] idx,
    input  logic          cin,
    input  logic          tbit,
    output logic [W-1:0]  r,
    output logic          c
);
    localparam int HALF = W / 2;

    logic [W-1:0] tload;

    // bit insert of the stored T flag, one mux per position
    for (genvar k = 0; k < W; k++) begin : g_tld
        assign tload[k] = (idx == IW'(k)) ? tbit : a[k];
    end

    always_comb begin
        r = a;
        c = 1'b0;
        unique case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_COM:  r = ~a;
            OP_INC:  r = a + {{(W-1){1'b0}}, 1'b1};
            OP_DEC:  r = a - {{(W-1){1'b0}}, 1'b1};
            OP_LSL: begin r = {a[W-2:0], 1'b0};   c = a[W-1]; end
            OP_LSR: begin r = {1'b0, a[W-1:1]};   c = a[0];   end
            OP_ROL: begin r = {a[W-2:0], cin};    c = a[W-1]; end
            OP_ROR: begin r = {cin, a[W-1:1]};    c = a[0];   end
            OP_ASR: begin r = {a[W-1], a[W-1:1]}; c = a[0];   end
            OP_SWAP: r = {a[HALF-1:0], a[W-1:HALF]};
            OP_TLD:  r = tload;
            default: r = a;
        endcase
    end

endmodule

// File: rtl/ralu_core.sv
module ralu_core
    import ralu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [4:0]   op_sel,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result,
    output logic [7:0]   flags
);
    localparam int IW = $clog2(W);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    alu_op_e       op;
    flag_t         flags_q;
    flag_t         flags_d;
    logic [IW-1:0] idx;

    logic [W-1:0]  as_x;
    logic [W-1:0]  as_y;
    logic          as_cin;
    logic          as_sub;
    logic [W-1:0]  as_r;
    logic          as_c;
    logic          as_h;
    logic          as_v;
    logic [W-1:0]  bo_r;
    logic          bo_c;

    assign op  = alu_op_e'(op_sel);
    assign idx = opb[IW-1:0];

    // operand steering for the shared adder; NEG is formed as zero minus opa
    always_comb begin
        as_x   = opa;
        as_y   = opb;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC:           as_cin = flags_q.c;
            OP_SUB, OP_CP:    as_sub = 1'b1;
            OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = flags_q.c; end
            OP_NEG: begin as_x = '0; as_y = opa; as_sub = 1'b1; end
            default: ;
        endcase
    end

    ralu_addsub #(.W(W)) u_addsub (
        .x   (as_x),
        .y   (as_y),
        .cin (as_cin),
        .sub (as_sub),
        .r   (as_r),
        .c   (as_c),
        .h   (as_h),
        .v   (as_v)
    );

    ralu_bitops #(.W(W)) u_bitops (
        .op   (op),
        .a    (opa),
        .b    (opb),
        .idx  (idx),
        .cin  (flags_q.c),
        .tbit (flags_q.t),
        .r    (bo_r),
        .c    (bo_c)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_CP, OP_CPC, OP_NEG: result = as_r;
            default:               result = bo_r;
        endcase
    end

    // next-state of the flag word
    always_comb begin
        flag_t      f;
        logic [7:0] fv;
        logic       nv_wr;
        f     = flags_q;
        nv_wr = 1'b1;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                f.c = as_c;
                f.h = as_h;
                f.v = as_v;
            end
            OP_AND, OP_OR, OP_XOR: f.v = 1'b0;
            OP_COM: begin f.c = 1'b1; f.v = 1'b0; end
            OP_INC: f.v = (result == MIN_NEG);
            OP_DEC: f.v = (result == MAX_POS);
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                f.c = bo_c;
                f.v = result[W-1] ^ bo_c;
            end
            default: nv_wr = 1'b0;
        endcase
        if (nv_wr) begin
            f.n = result[W-1];
            f.z = (result == '0);
            f.s = f.n ^ f.v;
        end
        fv = f;
        unique case (op)
            OP_FSET: fv[opb[FLAG_IDX_W-1:0]] = 1'b1;
            OP_FCLR: fv[opb[FLAG_IDX_W-1:0]] = 1'b0;
            OP_TST:  fv[6] = opa[idx];
            default: ;
        endcase
        flags_d = op_valid ? flag_t'(fv) : flags_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/ralu_chk.sv
module ralu_chk
    import ralu_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [4:0]   op_sel,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [7:0]   flags
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> flags == $past(flags)); // R12

    AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_SWAP) |=> flags == $past(flags)); // R8

    AST_COM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_COM) |=> (flags[0] && !flags[3])); // R6

    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel <= OP_ASR) |=> flags[4] == (flags[2] ^ flags[3])); // R11

    AST_EQ_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_CP && opa == opb) |=> (flags[1] && !flags[0])); // R3

    AST_LOGIC_VCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel inside {OP_AND, OP_OR, OP_XOR})
        |=> (!flags[3] && flags[0] == $past(flags[0]))); // R4

    AST_FSET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_FSET) |=> flags[$past(opb[2:0])]); // R9

endmodule

bind ralu_core ralu_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .opa      (opa),
    .opb      (opb),
    .flags    (flags)
);

// File: tb/sim_ralu_core.sv
`timescale 1ns/1ps
module sim_ralu_core;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [4:0] op_sel;
    logic [7:0] opa;
    logic [7:0] opb;
    logic [7:0] res_w;
    logic [7:0] flg_w;

    always #2.5 clk = ~clk;

    ralu_core #(.W(8)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_sel   (op_sel),
        .opa      (opa),
        .opb      (opb),
        .result   (res_w),
        .flags    (flg_w)
    );

    typedef struct {
        logic [7:0] res;
        logic [7:0] flg;
        bit         chk_res;
        bit         nv;
        string      tag;
    } item_t;

    item_t      sb[$];
    int         checks = 0;
    int         errors = 0;
    logic [7:0] mflags;
    bit         done = 0;

    function automatic int sx(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic string tag_of(input int op);
        if (op <= 1)  return "R2";
        if (op <= 5)  return "R3";
        if (op <= 8)  return "R4";
        if (op <= 10) return "R6";
        if (op <= 12) return "R5";
        if (op <= 17) return "R7";
        if (op == 19 || op == 20) return "R9";
        if (op == 21 || op == 22) return "R10";
        return "R8";
    endfunction

    // independent reference of the requirements
    function automatic void model(input int op, input int a, input int b,
                                  input logic [7:0] f,
                                  output logic [7:0] r_o, output logic [7:0] f_o,
                                  output bit nv);
        int r, d, sr, ci, ix;
        logic i, t, h, s, v, n, z, c;
        {i, t, h, s, v, n, z, c} = f;
        ix = b & 7;
        nv = 1;
        r  = a;
        case (op)
            0, 1: begin
                ci = (op == 1) ? int'(f[0]) : 0;
                r  = a + b + ci;
                h  = ((a & 15) + (b & 15) + ci) > 15;
                sr = sx(a) + sx(b) + ci;
                v  = (sr > 127) || (sr < -128);
                c  = r > 255;
                r  = r & 255;
            end
            2, 3, 4, 5: begin
                ci = (op == 3 || op == 5) ? int'(f[0]) : 0;
                d  = a - b - ci;
                c  = d < 0;
                h  = ((a & 15) - (b & 15) - ci) < 0;
                sr = sx(a) - sx(b) - ci;
                v  = (sr > 127) || (sr < -128);
                r  = d & 255;
            end
            6: begin r = a & b; v = 0; end
            7: begin r = a | b; v = 0; end
            8: begin r = a ^ b; v = 0; end
            9: begin r = 255 - a; c = 1; v = 0; end
            10: begin
                r = (0 - a) & 255;
                c = (a != 0);
                h = ((a & 15) != 0);
                v = (a == 128);
            end
            11: begin r = (a + 1) & 255; v = (a == 127); end
            12: begin r = (a - 1) & 255; v = (a == 128); end
            13: begin c = ((a >> 7) & 1) != 0; r = (a << 1) & 255; end
            14: begin c = (a & 1) != 0; r = a >> 1; end
            15: begin c = ((a >> 7) & 1) != 0; r = ((a << 1) | int'(f[0])) & 255; end
            16: begin c = (a & 1) != 0; r = (a >> 1) | (int'(f[0]) << 7); end
            17: begin c = (a & 1) != 0; r = (a >> 1) | (a & 128); end
            18: begin nv = 0; r = ((a & 15) << 4) | (a >> 4); end
            22: begin
                nv = 0;
                r  = t ? (a | (1 << ix)) : (a & ~(1 << ix) & 255);
            end
            default: nv = 0;
        endcase
        if (nv) begin
            n = ((r >> 7) & 1) != 0;
            z = (r == 0);
            if (op >= 13 && op <= 17) v = n ^ c;
            s = n ^ v;
        end
        f_o = {i, t, h, s, v, n, z, c};
        if (op == 19) f_o[ix] = 1'b1;
        if (op == 20) f_o[ix] = 1'b0;
        if (op == 21) f_o[6] = ((a >> ix) & 1) != 0;
        r_o = r[7:0];
    endfunction

    task automatic do_op(input int op, input int a, input int b);
        item_t it;
        logic [7:0] r, fo;
        bit nv;
        @(negedge clk);
        op_valid = 1'b1;
        op_sel   = op[4:0];
        opa      = a[7:0];
        opb      = b[7:0];
        model(op, a, b, mflags, r, fo, nv);
        it.res = r; it.flg = fo; it.chk_res = 1; it.nv = nv; it.tag = tag_of(op);
        sb.push_back(it);
        mflags = fo;
    endtask

    task automatic do_idle();
        item_t it;
        @(negedge clk);
        op_valid = 1'b0;
        op_sel   = 5'($urandom_range(23, 0));
        opa      = 8'($urandom);
        opb      = 8'($urandom);
        it.res = 8'h00; it.flg = mflags; it.chk_res = 0; it.nv = 0; it.tag = "R12";
        sb.push_back(it);
    endtask

    // monitor: result 1 ns after the drive edge, flags 1 ns after the next rising edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                if (it.chk_res) begin
                    checks++;
                    if (res_w !== it.res) begin
                        errors++;
                        $display("FAIL %s result: actual %02h expected %02h", it.tag, res_w, it.res);
                    end
                end
                @(posedge clk);
                #1;
                checks++;
                if (flg_w !== it.flg) begin
                    errors++;
                    $display("FAIL %s flags: actual %08b expected %08b", it.tag, flg_w, it.flg);
                end
                if (it.nv) begin
                    checks++;
                    if (flg_w[4] !== (flg_w[2] ^ flg_w[3])) begin
                        errors++;
                        $display("FAIL R11 sign: actual %b expected %b", flg_w[4], flg_w[2] ^ flg_w[3]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_sel = '0; opa = '0; opb = '0;
        mflags = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (flg_w !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset flags: actual %02h expected 00", flg_w);
        end
        @(negedge clk);
        rst_n = 1'b1;
        do_idle();
        // R2 corners: signed overflow with half carry, full carry to zero, chained carry
        do_op(0, 8'h7F, 8'h01);
        do_op(0, 8'hFF, 8'h01);
        do_op(1, 8'h10, 8'h20);
        do_op(19, 0, 0);
        do_op(1, 8'hFF, 8'h00);
        // R3 corners: borrow from zero, equal compare, borrowed compare
        do_op(2, 8'h00, 8'h01);
        do_op(3, 8'h80, 8'h00);
        do_op(4, 8'h5A, 8'h5A);
        do_op(19, 0, 0);
        do_op(5, 8'h5A, 8'h5A);
        do_op(2, 8'h10, 8'h01);
        // R6 corners
        do_op(10, 8'h80, 0);
        do_op(10, 8'h00, 0);
        do_op(10, 8'h01, 0);
        do_op(9, 8'h0F, 0);
        // R5 corners
        do_op(11, 8'h7F, 0);
        do_op(11, 8'hFF, 0);
        do_op(12, 8'h80, 0);
        do_op(12, 8'h00, 0);
        // R4 with carry kept
        do_op(19, 0, 0);
        do_op(6, 8'hF0, 8'h0F);
        do_op(8, 8'hAA, 8'h55);
        // R7 with both carry states
        do_op(15, 8'h80, 0);
        do_op(16, 8'h01, 0);
        do_op(17, 8'h81, 0);
        do_op(13, 8'h40, 0);
        do_op(14, 8'h01, 0);
        // R8, R9, R10
        do_op(18, 8'h3C, 0);
        do_op(23, 8'h00, 0);
        for (int k = 0; k < 8; k++) do_op(19, 8'h00, k);
        for (int k = 0; k < 8; k++) do_op(20, 8'h00, k);
        do_op(21, 8'h20, 5);
        do_op(22, 8'h00, 3);
        do_op(21, 8'hDF, 5);
        do_op(22, 8'hFF, 7);
        do_idle();
        do_idle();
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(7, 0) == 0) do_idle();
            else do_op(int'($urandom_range(23, 0)), int'($urandom_range(255, 0)),
                       int'($urandom_range(255, 0)));
        end
        do_idle();
        wait (sb.size() == 0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule